// File: doc/BRIEF.md
# ATM Cell Input Port with HEC Handling

This block is the cell entry point of a transmit path. An ATM-layer device pushes 53-byte cells over an 8-bit UTOPIA Level 1 or Level 2 transmit interface. The block is either one PHY (single-PHY mode) or a set of addressable ports that the ATM layer polls and selects (multi-PHY mode). Each port stores up to `BUF_CELLS` whole cells. Cells leave on a valid/ready byte stream tagged with the port number, one port at a time, and always as whole cells.

On the way in, every byte is checked for parity. The header error control byte (the fifth byte) can be verified against a CRC of the first four bytes. It can also be overwritten with a freshly computed value, with or without the standard coset. Errors are flagged with the cell but never cause it to be dropped. A start-of-cell that arrives in the middle of a cell throws away the partial cell and raises a one-cycle error pulse.

The output stream follows valid/ready rules:
- A beat moves on a rising edge where both `out_valid` and `out_ready` are high.
- While `out_valid` is high and `out_ready` is low, the beat holds still.
- Once the first byte of a cell is offered, the remaining 52 bytes of that cell come from the same port before any other port is served.
- Back-pressure fills the per-port buffers, which in turn withdraws cell-available on the input side.

Configuration pins are static; change them only while no cell is in flight.

Top module: `atm_cell_in`

## Requirements
- R1: A cell is 53 transfers. A transfer happens on each rising edge with `utx_enb_n` low, and `utx_soc` is high on the first byte. An accepted cell leaves on the output as 53 beats with its port number, and `out_last` is high only on the 53rd beat.
- R2: In multi-PHY mode, `utx_clav` in a cycle reports the port whose address was on `utx_addr` at the previous rising edge. Bytes go to the port whose address was last sampled while `utx_enb_n` was high.
- R3: When a port's bit in `cfg_port_en` is 0, that port never reports cell-available, and any cell sent to it is discarded.
- R4: With `cfg_mphy` low, the address is ignored. Cell-available and all cells belong to port 0.
- R5: Parity is checked on every byte. With `cfg_par_odd`=1, the byte plus `utx_par` must have an odd number of ones; with 0, an even number. Any bad byte in a cell sets `out_par_err` on that cell's last beat, and the cell is still delivered.
- R6: With `cfg_hec_chk`=1, byte 5 is compared with CRC-8 (generator x^8+x^2+x+1, zero start, MSB first) over bytes 1 to 4, XORed with 0x55 when `cfg_coset_en`=1. A mismatch sets `out_hec_err` on the last beat.
- R7: With `cfg_hec_gen`=1, byte 5 on the output is replaced by that CRC value (with the coset applied as in R6). Otherwise it passes unchanged.
- R8: With `cfg_coset_en`=0, the raw CRC is used for both checking and generation.
- R9: A port reports cell-available only when its committed bytes, plus 53 for a cell it is currently receiving, plus 53 more fit into `BUF_CELLS`*53 bytes. A cell that starts at a port without that room is discarded.
- R10: A start-of-cell arriving while a cell is in progress discards the partial cell and pulses `soc_err` in the next cycle. The new byte begins a fresh cell.
- R11: Bytes transferred outside a cell without `utx_soc` are ignored and produce no output.
- R12: While `out_valid` is high and `out_ready` is low, the output beat is held. `out_par_err` and `out_hec_err` are 0 on every beat except the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mphy | input | 1 | 1 = multi-PHY addressing, 0 = single PHY |
| cfg_port_en | input | 2**AW | Per-port enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_hec_chk | input | 1 | Verify incoming HEC |
| cfg_hec_gen | input | 1 | Regenerate HEC on output |
| cfg_coset_en | input | 1 | Apply 0x55 coset to the HEC |
| utx_addr | input | AW | Port address for polling and selection |
| utx_enb_n | input | 1 | Active-low transfer enable |
| utx_soc | input | 1 | Start of cell, high with first byte |
| utx_data | input | 8 | Cell byte |
| utx_par | input | 1 | Parity bit for `utx_data` |
| utx_clav | output | 1 | Cell available for the polled port |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take a beat |
| out_data | output | 8 | Output byte |
| out_port | output | AW | Port the cell came from |
| out_last | output | 1 | Last byte of cell |
| out_par_err | output | 1 | Parity error in cell (last beat only) |
| out_hec_err | output | 1 | HEC mismatch in cell (last beat only) |
| soc_err | output | 1 | One-cycle pulse: cell aborted by early start-of-cell |

## Verification
Cell-available is due in the cycle after its address was sampled, and `soc_err` is due in the cycle after the aborting byte. A whole cell becomes visible on the output in the cycle after the edge that took its 53rd byte. The bench's reference model applies each rising edge's inputs to its own state, using the state from before that edge. It compares `utx_clav` and `soc_err` at the following falling edge, where every registered result of that edge has settled. Output beats are matched at falling edges against per-port expected queues, and each matched beat decrements the model's buffer count at the next rising edge, just as the hardware does.

// File: rtl/atm_cell_in_pkg.sv
package atm_cell_in_pkg;
  localparam int CELL_LEN = 53;
  localparam int HEC_POS = 4;
  localparam logic [7:0] HEC_COSET = 8'h55;

  typedef struct packed {
    logic       herr;
    logic       perr;
    logic       last;
    logic [7:0] data;
  } cell_word_t;

  // one byte of CRC-8, generator x^8+x^2+x+1, MSB first
  function automatic logic [7:0] hec_step(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    c = crc ^ b;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    return c;
  endfunction
endpackage

// File: rtl/cellin_front.sv
module cellin_front
  import atm_cell_in_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_mphy,
  input  logic [(1<<AW)-1:0]   cfg_port_en,
  input  logic                 cfg_par_odd,
  input  logic                 cfg_hec_chk,
  input  logic                 cfg_hec_gen,
  input  logic                 cfg_coset_en,
  input  logic [AW-1:0]        tx_addr,
  input  logic                 tx_enb_n,
  input  logic                 tx_soc,
  input  logic [7:0]           tx_data,
  input  logic                 tx_par,
  input  logic [(1<<AW)-1:0]   port_room,
  output logic                 clav,
  output logic [(1<<AW)-1:0]   wr_en,
  output cell_word_t           wr_word,
  output logic                 commit,
  output logic [(1<<AW)-1:0]   rewind,
  output logic [(1<<AW)-1:0]   inprog,
  output logic                 soc_err
);
  localparam int NP = 1 << AW;
  localparam int IW = $clog2(CELL_LEN);

  logic [AW-1:0] last_addr, cur_port, poll_port, sel_port, wr_port;
  logic          in_cell, drop, clav_q, soc_err_q;
  logic [IW-1:0] idx;
  logic [7:0]    crc, hec_ref;
  logic          perr_acc, herr_acc;
  logic          xfer, start, cont, abort, new_drop, par_bad;
  logic          at_hec, at_end, perr_now, herr_now, wr_ok;

  always_comb begin
    poll_port = cfg_mphy ? tx_addr : '0;
    sel_port  = cfg_mphy ? last_addr : '0;
    xfer      = !tx_enb_n;
    par_bad   = cfg_par_odd ? ~(^{tx_data, tx_par}) : (^{tx_data, tx_par});
    start     = xfer && tx_soc;
    cont      = xfer && !tx_soc && in_cell;
    abort     = start && in_cell;
    new_drop  = !cfg_port_en[sel_port] || !port_room[sel_port];
    hec_ref   = crc ^ (cfg_coset_en ? HEC_COSET : 8'h00);
    at_hec    = cont && (idx == IW'(HEC_POS));
    at_end    = cont && (idx == IW'(CELL_LEN - 1));
    perr_now  = perr_acc | par_bad;
    herr_now  = herr_acc | (at_hec && cfg_hec_chk && (tx_data != hec_ref));
    wr_word.data = (at_hec && cfg_hec_gen) ? hec_ref : tx_data;
    wr_word.last = at_end;
    wr_word.perr = at_end && perr_now;
    wr_word.herr = at_end && herr_now;
    wr_port   = start ? sel_port : cur_port;
    wr_ok     = start ? !new_drop : (cont && !drop);
    commit    = at_end;
    for (int p = 0; p < NP; p++) begin
      wr_en[p]  = wr_ok && (wr_port == AW'(p));
      rewind[p] = abort && !drop && (cur_port == AW'(p));
      inprog[p] = in_cell && !drop && (cur_port == AW'(p));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      cur_port  <= '0;
      in_cell   <= 1'b0;
      drop      <= 1'b0;
      idx       <= '0;
      crc       <= '0;
      perr_acc  <= 1'b0;
      herr_acc  <= 1'b0;
      clav_q    <= 1'b0;
      soc_err_q <= 1'b0;
    end else begin
      if (tx_enb_n) last_addr <= tx_addr;
      clav_q    <= cfg_port_en[poll_port] && port_room[poll_port];
      soc_err_q <= abort;
      if (start) begin
        in_cell  <= 1'b1;
        drop     <= new_drop;
        cur_port <= sel_port;
        idx      <= IW'(1);
        crc      <= hec_step(8'h00, tx_data);
        perr_acc <= par_bad;
        herr_acc <= 1'b0;
      end else if (cont) begin
        idx      <= idx + IW'(1);
        if (idx < IW'(HEC_POS)) crc <= hec_step(crc, tx_data);
        perr_acc <= perr_now;
        herr_acc <= herr_now;
        if (at_end) in_cell <= 1'b0;
      end
    end
  end

  assign clav    = clav_q;
  assign soc_err = soc_err_q;
endmodule

// File: rtl/cellin_buf.sv
module cellin_buf
  import atm_cell_in_pkg::*;
#(
  parameter int DEPTH = 106
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  cell_word_t wr_word,
  input  logic       commit,
  input  logic       rewind,
  input  logic       inprog,
  input  logic       rd_en,
  output cell_word_t rd_word,
  output logic       nonempty,
  output logic       room
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  cell_word_t    mem [DEPTH];
  logic [PW-1:0] wp, wpc, rp, base;
  logic [CW-1:0] cnt_c;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign base     = rewind ? wpc : wp;
  assign rd_word  = mem[rp];
  assign nonempty = (cnt_c != '0);
  assign room     = (int'(cnt_c) + (inprog ? CELL_LEN : 0) + CELL_LEN) <= DEPTH;

  always_ff @(posedge clk) begin
    if (wr_en) mem[base] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      wpc   <= '0;
      rp    <= '0;
      cnt_c <= '0;
    end else begin
      if (wr_en) begin
        wp <= nxt(base);
        if (commit) wpc <= nxt(base);
      end else if (rewind) begin
        wp <= wpc;
      end
      if (rd_en) rp <= nxt(rp);
      cnt_c <= cnt_c + ((wr_en && commit) ? CW'(CELL_LEN) : '0) - CW'(rd_en);
    end
  end
endmodule

// File: rtl/cellin_out.sv
module cellin_out
  import atm_cell_in_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [(1<<AW)-1:0]             nonempty,
  input  cell_word_t [(1<<AW)-1:0]       words,
  input  logic                           out_ready,
  output logic                           out_valid,
  output logic [AW-1:0]                  out_port,
  output cell_word_t                     out_word,
  output logic [(1<<AW)-1:0]             rd_en
);
  localparam int NP = 1 << AW;

  logic          busy, any, hs;
  logic [AW-1:0] cur, pick;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int p = NP - 1; p >= 0; p--) begin
      if (nonempty[p]) begin
        pick = AW'(p);
        any  = 1'b1;
      end
    end
    out_port  = busy ? cur : pick;
    out_valid = busy || any;
    out_word  = words[out_port];
    hs        = out_valid && out_ready;
    for (int p = 0; p < NP; p++) rd_en[p] = hs && (out_port == AW'(p));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cur  <= '0;
    end else if (out_valid) begin
      busy <= !(hs && out_word.last);
      cur  <= out_port;
    end
  end
endmodule

// File: rtl/atm_cell_in.sv
module atm_cell_in
  import atm_cell_in_pkg::*;
#(
  parameter int AW = 2,
  parameter int BUF_CELLS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_mphy,
  input  logic [(1<<AW)-1:0] cfg_port_en,
  input  logic               cfg_par_odd,
  input  logic               cfg_hec_chk,
  input  logic               cfg_hec_gen,
  input  logic               cfg_coset_en,
  input  logic [AW-1:0]      utx_addr,
  input  logic               utx_enb_n,
  input  logic               utx_soc,
  input  logic [7:0]         utx_data,
  input  logic               utx_par,
  output logic               utx_clav,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  output logic [AW-1:0]      out_port,
  output logic               out_last,
  output logic               out_par_err,
  output logic               out_hec_err,
  output logic               soc_err
);
  localparam int NP = 1 << AW;
  localparam int DEPTH = BUF_CELLS * CELL_LEN;

  logic [NP-1:0]        room, wr_en, rewind, inprog, nonempty, rd_en;
  logic                 commit;
  cell_word_t           wr_word, out_word;
  cell_word_t [NP-1:0]  rd_words;

  cellin_front #(.AW(AW)) u_front (
    .clk(clk), .rst_n(rst_n), .cfg_mphy(cfg_mphy), .cfg_port_en(cfg_port_en),
    .cfg_par_odd(cfg_par_odd), .cfg_hec_chk(cfg_hec_chk), .cfg_hec_gen(cfg_hec_gen),
    .cfg_coset_en(cfg_coset_en), .tx_addr(utx_addr), .tx_enb_n(utx_enb_n),
    .tx_soc(utx_soc), .tx_data(utx_data), .tx_par(utx_par), .port_room(room),
    .clav(utx_clav), .wr_en(wr_en), .wr_word(wr_word), .commit(commit),
    .rewind(rewind), .inprog(inprog), .soc_err(soc_err)
  );

  for (genvar g = 0; g < NP; g++) begin : g_port
    cellin_buf #(.DEPTH(DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en[g]), .wr_word(wr_word),
      .commit(commit), .rewind(rewind[g]), .inprog(inprog[g]), .rd_en(rd_en[g]),
      .rd_word(rd_words[g]), .nonempty(nonempty[g]), .room(room[g])
    );
  end

  cellin_out #(.AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n), .nonempty(nonempty), .words(rd_words),
    .out_ready(out_ready), .out_valid(out_valid), .out_port(out_port),
    .out_word(out_word), .rd_en(rd_en)
  );

  assign out_data    = out_word.data;
  assign out_last    = out_word.last;
  assign out_par_err = out_word.perr;
  assign out_hec_err = out_word.herr;
endmodule

// File: rtl/cellin_chk.sv
module cellin_chk #(
  parameter int AW = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_mphy,
  input logic [(1<<AW)-1:0] cfg_port_en,
  input logic [AW-1:0]      utx_addr,
  input logic               utx_enb_n,
  input logic               utx_soc,
  input logic               utx_clav,
  input logic               out_valid,
  input logic               out_ready,
  input logic [7:0]         out_data,
  input logic [AW-1:0]      out_port,
  input logic               out_last,
  input logic               out_par_err,
  input logic               out_hec_err,
  input logic               soc_err
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_clav_mphy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && utx_clav && cfg_mphy) |-> cfg_port_en[$past(utx_addr)]);

  assert_clav_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (utx_clav && !cfg_mphy) |-> cfg_port_en[0]);

  assert_hold_beat_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_port) && $stable(out_last)));

  assert_flags_on_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> !(out_par_err || out_hec_err));

  assert_abort_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && soc_err) |-> $past(!utx_enb_n && utx_soc));
endmodule

bind atm_cell_in cellin_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mphy(cfg_mphy), .cfg_port_en(cfg_port_en),
  .utx_addr(utx_addr), .utx_enb_n(utx_enb_n), .utx_soc(utx_soc), .utx_clav(utx_clav),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_port(out_port),
  .out_last(out_last), .out_par_err(out_par_err), .out_hec_err(out_hec_err),
  .soc_err(soc_err)
);

// File: tb/test_atm_cell_in.sv
`timescale 1ns/1ps
module test_atm_cell_in;
  localparam int NCELL = 53;
  localparam int BUFB  = 2 * NCELL;

  logic clk = 0, rst_n = 0;
  logic cfg_mphy = 1, cfg_par_odd = 1, cfg_hec_chk = 1, cfg_hec_gen = 0, cfg_coset_en = 1;
  logic [3:0] cfg_port_en = 4'hF;
  logic [1:0] utx_addr = 0;
  logic utx_enb_n = 1, utx_soc = 0, utx_par = 0, out_ready = 1;
  logic [7:0] utx_data = 0;
  logic utx_clav, out_valid, out_last, out_par_err, out_hec_err, soc_err;
  logic [7:0] out_data;
  logic [1:0] out_port;

  int checks = 0, errors = 0;
  bit done = 0;
  bit rdy_toggle = 0;

  always #2.5 clk = ~clk;

  atm_cell_in i_atm_cell_in (
    .clk(clk), .rst_n(rst_n), .cfg_mphy(cfg_mphy), .cfg_port_en(cfg_port_en),
    .cfg_par_odd(cfg_par_odd), .cfg_hec_chk(cfg_hec_chk), .cfg_hec_gen(cfg_hec_gen),
    .cfg_coset_en(cfg_coset_en), .utx_addr(utx_addr), .utx_enb_n(utx_enb_n),
    .utx_soc(utx_soc), .utx_data(utx_data), .utx_par(utx_par), .utx_clav(utx_clav),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_port(out_port),
    .out_last(out_last), .out_par_err(out_par_err), .out_hec_err(out_hec_err),
    .soc_err(soc_err)
  );

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [31:0] h);
    logic [7:0] c = 8'h00;
    for (int i = 31; i >= 0; i--) c = {c[6:0], 1'b0} ^ ((c[7] ^ h[i]) ? 8'h07 : 8'h00);
    return c;
  endfunction

  // ---------------- reference model ----------------
  int q[4][$];
  int m_cnt[4];
  bit m_in, m_drop;
  int m_port, m_idx;
  bit m_perr;
  logic [7:0] m_bytes[NCELL];
  logic [1:0] m_last_addr;
  bit exp_clav, exp_soc;
  bit pend_pop;
  int pend_port;

  function automatic bit m_room(input int p);
    return (m_cnt[p] + ((m_in && !m_drop && m_port == p) ? NCELL : 0) + NCELL) <= BUFB;
  endfunction

  task automatic m_finish_cell();
    logic [7:0] hc;
    bit herr;
    hc   = ref_crc({m_bytes[0], m_bytes[1], m_bytes[2], m_bytes[3]}) ^ (cfg_coset_en ? 8'h55 : 8'h00);
    herr = cfg_hec_chk && (m_bytes[4] != hc);
    for (int i = 0; i < NCELL; i++) begin
      int w;
      w = (i == 4 && cfg_hec_gen) ? int'(hc) : int'(m_bytes[i]);
      if (i == NCELL - 1) w = w | (1 << 8) | (int'(m_perr) << 9) | (int'(herr) << 10);
      q[m_port].push_back(w);
    end
    m_cnt[m_port] += NCELL;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_in = 0; m_drop = 0; m_last_addr = 0; exp_clav = 0; exp_soc = 0; pend_pop = 0;
      for (int p = 0; p < 4; p++) m_cnt[p] = 0;
    end else begin
      int pa, sp;
      bit bad, rsp;
      pa  = cfg_mphy ? int'(utx_addr) : 0;
      sp  = cfg_mphy ? int'(m_last_addr) : 0;
      exp_clav = cfg_port_en[pa] && m_room(pa);
      rsp = m_room(sp);
      exp_soc = 0;
      bad = cfg_par_odd ? !(^{utx_data, utx_par}) : (^{utx_data, utx_par});
      if (!utx_enb_n) begin
        if (utx_soc) begin
          if (m_in) exp_soc = 1;
          m_in = 1; m_drop = !cfg_port_en[sp] || !rsp; m_port = sp;
          m_idx = 1; m_bytes[0] = utx_data; m_perr = bad;
        end else if (m_in) begin
          m_bytes[m_idx] = utx_data;
          m_perr = m_perr | bad;
          if (m_idx == NCELL - 1) begin
            m_in = 0;
            if (!m_drop) m_finish_cell();
          end
          m_idx++;
        end
      end else begin
        m_last_addr = utx_addr;
      end
      if (pend_pop) begin
        m_cnt[pend_port]--;
        pend_pop = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(utx_clav, exp_clav, "R2 R3 R4 R9 cell-available");
      chk(soc_err, exp_soc, "R10 soc_err pulse");
      if (out_valid && out_ready) begin
        int act;
        act = out_data | (out_last << 8) | (out_par_err << 9) | (out_hec_err << 10);
        if (q[out_port].size() == 0) begin
          chk(act, -1, "R1 R3 R11 unexpected output beat");
        end else begin
          chk(act, q[out_port].pop_front(), "R1 R5 R6 R7 R8 R12 output beat");
        end
        pend_pop = 1; pend_port = out_port;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(posedge clk); #1;
    if (rdy_toggle) out_ready = ~out_ready;
  endtask

  task automatic send_cell(input int port, input int seed, input bit bad_hec,
                           input int bad_par, input int abort_at, input bit no_sel);
    logic [7:0] b[NCELL];
    for (int i = 0; i < NCELL; i++) b[i] = 8'((seed * 7 + i * 13 + seed * i) & 255);
    b[4] = ref_crc({b[0], b[1], b[2], b[3]}) ^ (cfg_coset_en ? 8'h55 : 8'h00);
    if (bad_hec) b[4] = b[4] ^ 8'hA5;
    if (!no_sel) begin
      utx_enb_n = 1; utx_addr = 2'(port); utx_soc = 0;
      step();
    end
    for (int i = 0; i < NCELL; i++) begin
      if (i == abort_at) return;
      utx_enb_n = 0; utx_soc = (i == 0); utx_data = b[i];
      utx_par = cfg_par_odd ? ~(^b[i]) : (^b[i]);
      if (i == bad_par) utx_par = ~utx_par;
      step();
    end
    utx_enb_n = 1; utx_soc = 0;
    step();
  endtask

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      if (q[0].size() + q[1].size() + q[2].size() + q[3].size() == 0 && !out_valid) break;
      step();
    end
    step();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(utx_clav, 0, "R2 reset cell-available");
    chk(out_valid, 0, "R1 reset out_valid");
    chk(soc_err, 0, "R10 reset soc_err");
    rst_n = 1;
    step();

    // R2: polling every port in multi-PHY mode
    for (int p = 0; p < 4; p++) begin utx_addr = 2'(p); step(); end
    // R1 R6 clean cell, bad HEC, parity error
    send_cell(0, 3, 0, -1, -1, 0);
    send_cell(2, 9, 1, -1, -1, 0);
    send_cell(3, 21, 0, 10, -1, 0);
    drain();
    // R7: regenerate HEC with output back-pressure pattern (R12)
    cfg_hec_gen = 1; rdy_toggle = 1;
    send_cell(1, 40, 1, -1, -1, 0);
    send_cell(2, 41, 0, 52, -1, 0);
    drain();
    rdy_toggle = 0; out_ready = 1;
    // R8: coset off, R5 even parity
    cfg_coset_en = 0; cfg_par_odd = 0;
    send_cell(0, 55, 0, -1, -1, 0);
    send_cell(3, 56, 1, 0, -1, 0);
    drain();
    cfg_coset_en = 1; cfg_par_odd = 1; cfg_hec_gen = 0;
    // R3: disabled port discards
    cfg_port_en = 4'b1101;
    utx_addr = 2'd1; step(); step();
    chk(utx_clav, 0, "R3 disabled port cell-available");
    send_cell(1, 60, 0, -1, -1, 0);
    repeat (5) step();
    chk(out_valid, 0, "R3 disabled port cell discarded");
    cfg_port_en = 4'hF;
    // R10: early start-of-cell aborts
    send_cell(2, 70, 0, -1, 20, 0);
    send_cell(2, 71, 0, -1, -1, 1);
    drain();
    // R11: stray bytes outside a cell
    utx_enb_n = 0; utx_soc = 0;
    for (int i = 0; i < 5; i++) begin utx_data = 8'(i + 1); step(); end
    utx_enb_n = 1; repeat (4) step();
    chk(out_valid, 0, "R11 stray bytes ignored");
    // R9: fill port 1 under full back-pressure
    out_ready = 0;
    send_cell(1, 80, 0, -1, -1, 0);
    send_cell(1, 81, 0, -1, -1, 0);
    utx_addr = 2'd1; step(); step();
    chk(utx_clav, 0, "R9 full port withdraws cell-available");
    send_cell(1, 82, 0, -1, -1, 0);
    out_ready = 1;
    drain();
    // R4: single-PHY mode, address ignored
    cfg_mphy = 0;
    send_cell(3, 90, 0, -1, -1, 0);
    send_cell(2, 91, 1, 7, -1, 0);
    drain();
    for (int p = 0; p < 4; p++) chk(q[p].size(), 0, "R1 all expected cells delivered");
    done = 1;
    summary();
    $finish;
  end
endmodule